// File: doc/BRIEF.md
# Shared Memory Priority Arbiter

This block lets five requesters share one single-port 32 KB data RAM. Requesters 0 and 1 are the two cores of the first real-time cluster. Requesters 2 and 3 are the two cores of the second cluster, and they share one priority level. Requester 4 is the external host port. Each requester raises a request with a byte address, a direction and a burst length in 32-bit words. The arbiter accepts one command at a time by fixed priority and then owns the RAM for that burst, moving one word per cycle.

Priority only matters when a command is accepted. A burst that has started always runs to its end, so a long host burst stalls every core for its whole length. Single-word transfers keep that stall to a minimum. The RAM model inside the block is a behavioural synchronous single-port array.

Top module: `shmem_prio_arb`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every `gnt_o`, `beat_o`, `rvalid_o` and `done_o` bit is low.
- R2: When several requesters are pending at an accept, the winner is chosen in this order, highest first: index 0, then index 1, then the pair {2, 3}, then index 4.
- R3: A tie between indices 2 and 3 goes to index 2 when the pair pointer is 0 and to index 3 when it is 1. The pointer is 0 after reset and toggles on every grant to index 2 or 3.
- R4: A command raised in cycle t while the arbiter is idle gets its `gnt_o` pulse in cycle t+1. For a read, the first word appears with `rvalid_o` in cycle t+2.
- R5: The `len` field encodes a burst of len+1 words (1 to 16). Beat k addresses the word at the start address plus 4·k bytes, and one beat is moved per cycle.
- R6: A burst in progress is never preempted. A higher-priority request that arrives after another requester's grant is not granted before that burst's `done_o`.
- R7: `done_o` of the owner is a one-cycle pulse on the final beat of a burst. For a read it coincides with the final `rvalid_o`. For a write it arrives in the cycle after the last `beat_o` cycle.
- R8: Arbitration resumes in the cycle where `done_o` is shown, so a request held high during someone else's burst is granted in the cycle after that `done_o`.
- R9: The RAM word used is byte address bits [14:2], so addresses wrap modulo 32 KB, address bits [1:0] are ignored, and a burst crossing the top word continues at word 0.
- R10: At most one bit of each of `gnt_o`, `rvalid_o` and `done_o` is set in any cycle, and a grant only goes to a requester whose request was high in the cycle before.
- R11: For a write, beat k takes the owner's `wdata_i` slice from the k-th cycle in which its `beat_o` bit is high. A later read of that word returns the written value on `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 5 | Request per requester, held until its grant |
| we_i | input | 5 | Direction per requester, 1 = write |
| addr_i | input | 80 | Byte start address, 16 bits per requester |
| len_i | input | 20 | Burst length minus one, 4 bits per requester |
| wdata_i | input | 160 | Write data, 32 bits per requester |
| gnt_o | output | 5 | One-cycle pulse: command accepted |
| beat_o | output | 5 | Owner executes a beat at the end of this cycle |
| rvalid_o | output | 5 | Read word valid on rdata_o for this requester |
| done_o | output | 5 | One-cycle pulse on the final beat |
| rdata_o | output | 32 | Read data bus shared by all requesters |

## Verification
On every cycle the assertions check the priority of each grant against the requests of the cycle before, that outputs are one-hot, that the owner is held for the whole burst, the read latency after a grant, and the single-cycle done that falls in an idle cycle. The round-robin alternation inside the pair, the data integrity of bursts and wrap-around, and the exact stall a core sees behind a long host burst need scenarios. The bench shows these with directed collisions and random serial traffic that it compares against a shadow memory.

// File: rtl/shmem_arb_pkg.sv
package shmem_arb_pkg;
  localparam int NREQ  = 5;
  localparam int OWN_W = 3;

  // requester indices; the order is the priority order except for the shared pair
  typedef enum logic [OWN_W-1:0] {
    RQ_C1_0 = 3'd0,
    RQ_C1_1 = 3'd1,
    RQ_C0_A = 3'd2,
    RQ_C0_B = 3'd3,
    RQ_HOST = 3'd4
  } rq_id_e;
endpackage

// File: rtl/shmem_prio_pick.sv
module shmem_prio_pick
  import shmem_arb_pkg::*;
(
  input  logic [NREQ-1:0]  req_i,
  input  logic             rr_i,
  output logic             any_o,
  output logic [OWN_W-1:0] win_o
);
  always_comb begin
    any_o = |req_i;
    win_o = RQ_HOST;
    if (req_i[RQ_C1_0])                         win_o = RQ_C1_0;
    else if (req_i[RQ_C1_1])                    win_o = RQ_C1_1;
    else if (req_i[RQ_C0_A] && req_i[RQ_C0_B])  win_o = rr_i ? RQ_C0_B : RQ_C0_A;
    else if (req_i[RQ_C0_A])                    win_o = RQ_C0_A;
    else if (req_i[RQ_C0_B])                    win_o = RQ_C0_B;
  end
endmodule

// File: rtl/shmem_burst_ctl.sv
module shmem_burst_ctl
  import shmem_arb_pkg::*;
#(
  parameter int WIDX_W = 13,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_req_i,
  input  logic [OWN_W-1:0]  win_i,
  input  logic [WIDX_W-1:0] cmd_widx_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic              cmd_we_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              last_o,
  output logic [OWN_W-1:0]  owner_o,
  output logic [WIDX_W-1:0] widx_o,
  output logic              we_o,
  output logic              rr_o
);
  logic [LEN_W:0] left_q;

  assign accept_o = !busy_o && any_req_i;
  assign last_o   = busy_o && (left_q == (LEN_W+1)'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      owner_o <= '0;
      widx_o  <= '0;
      left_q  <= '0;
      we_o    <= 1'b0;
      rr_o    <= 1'b0;
    end else if (accept_o) begin
      busy_o  <= 1'b1;
      owner_o <= win_i;
      widx_o  <= cmd_widx_i;
      left_q  <= {1'b0, cmd_len_i} + (LEN_W+1)'(1);
      we_o    <= cmd_we_i;
      if (win_i == RQ_C0_A || win_i == RQ_C0_B) rr_o <= ~rr_o;
    end else if (busy_o) begin
      widx_o <= widx_o + WIDX_W'(1);
      left_q <= left_q - (LEN_W+1)'(1);
      if (last_o) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/shmem_ram_model.sv
module shmem_ram_model #(
  parameter int WORDS  = 8192,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (en_i) begin
      if (we_i) mem[idx_i] <= wdata_i;
      else      rdata_o    <= mem[idx_i];
    end
  end
endmodule

// File: rtl/shmem_prio_arb.sv
module shmem_prio_arb
  import shmem_arb_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LEN_W     = 4,
  parameter int DATA_W    = 32,
  parameter int RAM_BYTES = 32768
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_i,
  input  logic [NREQ-1:0]          we_i,
  input  logic [NREQ*ADDR_W-1:0]   addr_i,
  input  logic [NREQ*LEN_W-1:0]    len_i,
  input  logic [NREQ*DATA_W-1:0]   wdata_i,
  output logic [NREQ-1:0]          gnt_o,
  output logic [NREQ-1:0]          beat_o,
  output logic [NREQ-1:0]          rvalid_o,
  output logic [NREQ-1:0]          done_o,
  output logic [DATA_W-1:0]        rdata_o
);
  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int WORDS  = RAM_BYTES / BYTES_PER_WORD;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int BSH    = $clog2(BYTES_PER_WORD);

  // byte address to word index; the upper bits drop out so addresses wrap
  function automatic logic [WIDX_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return WIDX_W'(a >> BSH);
  endfunction

  // named internal events, observed by the bound checker
  logic              any_w, accept_w, busy_w, last_beat_w, xfer_we_w, rr_w;
  logic [OWN_W-1:0]  win_w, owner_w;
  logic [WIDX_W-1:0] cur_widx_w, cmd_widx;
  logic [LEN_W-1:0]  cmd_len;
  logic              cmd_we;
  logic [DATA_W-1:0] wdata_sel;

  shmem_prio_pick u_pick (
    .req_i (req_i),
    .rr_i  (rr_w),
    .any_o (any_w),
    .win_o (win_w)
  );

  always_comb begin
    cmd_widx  = '0;
    cmd_len   = '0;
    cmd_we    = 1'b0;
    wdata_sel = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (win_w == OWN_W'(i)) begin
        cmd_widx = word_of(addr_i[i*ADDR_W +: ADDR_W]);
        cmd_len  = len_i[i*LEN_W +: LEN_W];
        cmd_we   = we_i[i];
      end
      if (owner_w == OWN_W'(i)) wdata_sel = wdata_i[i*DATA_W +: DATA_W];
    end
  end

  shmem_burst_ctl #(.WIDX_W(WIDX_W), .LEN_W(LEN_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_req_i  (any_w),
    .win_i      (win_w),
    .cmd_widx_i (cmd_widx),
    .cmd_len_i  (cmd_len),
    .cmd_we_i   (cmd_we),
    .accept_o   (accept_w),
    .busy_o     (busy_w),
    .last_o     (last_beat_w),
    .owner_o    (owner_w),
    .widx_o     (cur_widx_w),
    .we_o       (xfer_we_w),
    .rr_o       (rr_w)
  );

  shmem_ram_model #(.WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .en_i    (busy_w),
    .we_i    (xfer_we_w),
    .idx_i   (cur_widx_w),
    .wdata_i (wdata_sel),
    .rdata_o (rdata_o)
  );

  for (genvar g = 0; g < NREQ; g++) begin : g_rq
    logic mine;
    assign mine      = busy_w && (owner_w == OWN_W'(g));
    assign beat_o[g] = mine;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gnt_o[g]    <= 1'b0;
        rvalid_o[g] <= 1'b0;
        done_o[g]   <= 1'b0;
      end else begin
        gnt_o[g]    <= accept_w && (win_w == OWN_W'(g));
        rvalid_o[g] <= mine && !xfer_we_w;
        done_o[g]   <= mine && last_beat_w;
      end
    end
  end
endmodule

// File: rtl/shmem_prio_arb_chk.sv
module shmem_prio_arb_chk
  import shmem_arb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NREQ-1:0]  req_i,
  input logic [NREQ-1:0]  gnt_o,
  input logic [NREQ-1:0]  rvalid_o,
  input logic [NREQ-1:0]  done_o,
  input logic             busy_w,
  input logic [OWN_W-1:0] owner_w,
  input logic             xfer_we_w,
  input logic             last_beat_w
);
  assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o) && $onehot0(rvalid_o) && $onehot0(done_o));

  assert_gnt_had_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0) |-> (($past(req_i) & gnt_o) == gnt_o));

  assert_c1_1_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o[1] |-> !$past(req_i[0]));

  assert_pair_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o[2] || gnt_o[3]) |-> !$past(req_i[0] || req_i[1]));

  assert_host_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o[4] |-> ($past(req_i[3:0]) == 4'b0));

  assert_no_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !last_beat_w) |=> (busy_w && $stable(owner_w)));

  assert_gnt_after_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o != '0) |-> !$past(busy_w));

  assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o != '0) && !xfer_we_w) |=> (rvalid_o == $past(gnt_o)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o != '0) |=> (done_o == '0));

  assert_read_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((done_o != '0) && !xfer_we_w) |-> (rvalid_o == done_o));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o != '0) |-> !busy_w);
endmodule

bind shmem_prio_arb shmem_prio_arb_chk u_chk (.*);

// File: tb/shmem_prio_arb_tb.sv
module shmem_prio_arb_tb;
  import shmem_arb_pkg::*;
  localparam int AW = 16, LW = 4, DW = 32, RAM_BYTES = 32768;
  localparam int WORDS = RAM_BYTES / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NREQ-1:0] req = '0, we = '0;
  logic [NREQ*AW-1:0] addr = '0;
  logic [NREQ*LW-1:0] len = '0;
  logic [NREQ*DW-1:0] wdata = '0;
  logic [NREQ-1:0] gnt_o, beat_o, rvalid_o, done_o;
  logic [DW-1:0] rdata_o;

  int errors = 0, checks = 0, pair_grants = 0;
  longint cyc = 0;
  bit finished = 1'b0;
  logic [31:0] shadow [int];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  shmem_prio_arb u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .len_i(len),
    .wdata_i(wdata), .gnt_o(gnt_o), .beat_o(beat_o), .rvalid_o(rvalid_o),
    .done_o(done_o), .rdata_o(rdata_o)
  );

  function automatic int word_at(input logic [15:0] a, input int k);
    return ((int'(a) % RAM_BYTES) / 4 + k) % WORDS;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic xfer(input int i, input bit w, input logic [15:0] a, input int n,
                      output longint t_cmd, output longint t_gnt,
                      output longint t_first, output longint t_done);
    int guard = 0;
    @(negedge clk);
    req[i] = 1'b1; we[i] = w; addr[i*AW +: AW] = a; len[i*LW +: LW] = LW'(n - 1);
    t_cmd = cyc; t_first = -1;
    while (!gnt_o[i] && guard < 400) begin @(negedge clk); guard++; end
    t_gnt = cyc;
    req[i] = 1'b0;
    if (i == 2 || i == 3) pair_grants++;
    if (w) begin
      for (int k = 0; k < n; k++) begin
        chk(beat_o[i], "R11 beat", beat_o[i], 1);
        wdata[i*DW +: DW] = $urandom;
        shadow[word_at(a, k)] = wdata[i*DW +: DW];
        if (k == 0) t_first = cyc;
        @(negedge clk);
      end
      t_done = cyc;
      chk(done_o[i], "R7 write done", done_o[i], 1);
    end else begin
      int k = 0;
      guard = 0;
      while (k < n && guard < 400) begin
        @(negedge clk); guard++;
        if (rvalid_o[i]) begin
          if (k == 0) t_first = cyc;
          if (shadow.exists(word_at(a, k)))
            chk(rdata_o == shadow[word_at(a, k)], "R11 read data", rdata_o, shadow[word_at(a, k)]);
          chk(done_o[i] == (k == n - 1), "R7 done on last beat", done_o[i], (k == n - 1));
          k++;
        end
      end
      t_done = cyc;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint tc, tg, tf, td;
    longint hc, hg, hf, hd;
    longint g [NREQ], d [NREQ], c [NREQ], f [NREQ];
    int first_pair;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    chk(gnt_o == 0 && beat_o == 0 && rvalid_o == 0 && done_o == 0, "R1 reset outputs",
        {gnt_o, beat_o, rvalid_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gnt_o == 0 && rvalid_o == 0 && done_o == 0, "R1 after release",
        {gnt_o, rvalid_o, done_o}, 0);

    // R4: uncontended single-word write then read
    xfer(0, 1'b1, 16'h0040, 1, tc, tg, tf, td);
    xfer(0, 1'b0, 16'h0040, 1, tc, tg, tf, td);
    chk(tg == tc + 1, "R4 grant latency", tg, tc + 1);
    chk(tf == tc + 2, "R4 read latency", tf, tc + 2);

    // R5 R11: 16-word burst write and readback
    xfer(1, 1'b1, 16'h0200, 16, tc, tg, tf, td);
    chk(td == tg + 16, "R5 write burst length", td, tg + 16);
    xfer(2, 1'b0, 16'h0200, 16, tc, tg, tf, td);
    chk(td == tg + 16, "R5 read burst length", td, tg + 16);

    // R9: wrap across the top word, ignored low bits, aliasing above 32 KB
    xfer(4, 1'b1, 16'h7FFC, 2, tc, tg, tf, td);
    xfer(3, 1'b0, 16'hFFFD, 1, tc, tg, tf, td);
    chk(rdata_o == shadow[WORDS - 1], "R9 alias of top word", rdata_o, shadow[WORDS - 1]);
    xfer(3, 1'b0, 16'h8000, 1, tc, tg, tf, td);
    chk(rdata_o == shadow[0], "R9 burst wrapped to word 0", rdata_o, shadow[0]);

    // R6 R8: host burst accepted one cycle before a core request
    @(negedge clk);
    fork
      xfer(4, 1'b0, 16'h0200, 8, hc, hg, hf, hd);
      begin @(negedge clk); xfer(0, 1'b0, 16'h0040, 1, tc, tg, tf, td); end
    join
    chk(tg > hd, "R6 core not granted before host done", tg, hd + 1);
    chk(tg == hd + 1, "R8 held request granted after done", tg, hd + 1);

    // R2 R3 R8: all five collide
    first_pair = (pair_grants % 2 == 0) ? 2 : 3;
    @(negedge clk);
    fork
      xfer(0, 1'b0, 16'h0200, 2, c[0], g[0], f[0], d[0]);
      xfer(1, 1'b0, 16'h0208, 2, c[1], g[1], f[1], d[1]);
      xfer(2, 1'b0, 16'h0210, 2, c[2], g[2], f[2], d[2]);
      xfer(3, 1'b0, 16'h0218, 2, c[3], g[3], f[3], d[3]);
      xfer(4, 1'b0, 16'h0220, 2, c[4], g[4], f[4], d[4]);
    join
    chk(g[0] < g[1], "R2 index 0 before 1", g[0], g[1]);
    chk(g[1] == d[0] + 1, "R8 index 1 right after done", g[1], d[0] + 1);
    chk(g[first_pair] == d[1] + 1, "R3 pair pointer choice", g[first_pair], d[1] + 1);
    chk(g[5 - first_pair] == d[first_pair] + 1, "R3 other pair member next",
        g[5 - first_pair], d[first_pair] + 1);
    chk(g[4] == d[5 - first_pair] + 1, "R2 host last", g[4], d[5 - first_pair] + 1);

    // R3: pair-only collision alternates with the pointer
    for (int rep = 0; rep < 2; rep++) begin
      first_pair = (pair_grants % 2 == 0) ? 2 : 3;
      @(negedge clk);
      fork
        xfer(2, 1'b0, 16'h0200, 1, c[2], g[2], f[2], d[2]);
        xfer(3, 1'b0, 16'h0200, 1, c[3], g[3], f[3], d[3]);
      join
      chk(g[first_pair] < g[5 - first_pair], "R3 round robin winner", g[first_pair], g[5 - first_pair]);
    end

    // random serial traffic against the shadow memory (R5 R11)
    for (int it = 0; it < 60; it++) begin
      int ri = $urandom % NREQ;
      bit rw = 1'((it < 10) ? 1 : $urandom % 2);
      int rn = 1 + $urandom % 16;
      logic [15:0] ra = 16'(16'h0400 + ($urandom % 64) * 4);
      xfer(ri, rw, ra, rn, tc, tg, tf, td);
      chk(td == tg + rn, "R5 random burst length", td, tg + rn);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule